// File: doc/BRIEF.md
# ADC Result Register Pair with Coherent Read Lock

This block stores the most recent conversion result of a bus-attached analog-to-digital converter. It presents that result to software as two byte-wide registers, a low byte and a high byte. A conversion engine delivers each result word together with a one-cycle done strobe. A simple register bus supplies one-cycle read strobes for each byte. A control input sets the alignment. With right alignment the 10 result bits sit at the bottom of the 16-bit pair. With left alignment they sit at the top, so a single high-byte read yields an 8-bit reading.

A read of the low byte locks the pair. While the pair is locked, no completed conversion may alter either byte. A later read of the high byte releases the lock. A low-then-high read sequence therefore always returns two halves of the same sample. A conversion that ends while the pair is locked is discarded. The block still raises its completion flag for that conversion, so software can see that a sample was missed. The flag stays set until it is cleared by a clear strobe.

Top module: `adc_result_regs`

## Requirements
- R1: After reset both data bytes read 0x00, the completion flag is 0 and the pair is unlocked, so the first completion after reset is captured.
- R2: With the align input at 0 (right), the low byte is result[7:0], and the high byte holds result[9:8] in bits 1:0 with bits 7:2 reading as zero.
- R3: With the align input at 1 (left), the high byte is result[9:2], and the low byte holds result[1:0] in bits 7:6 with bits 5:0 reading as zero.
- R4: In left alignment, reading only the high byte is a complete access: it returns result[9:2] and leaves the pair unlocked, so later completions are still captured.
- R5: A change of the align input re-formats the held result on the byte outputs in the same cycle, without a new conversion.
- R6: A low-byte read strobe locks the pair from the next cycle. A completion while the pair is locked leaves both bytes unchanged and discards that result.
- R7: A high-byte read strobe unlocks the pair from the next cycle. A completion after that is captured.
- R8: Every done strobe sets the completion flag in the next cycle, including a discarded one. The clear strobe resets the flag. If a done strobe and the clear strobe arrive in the same cycle, the flag is set.
- R9: A completion on an unlocked pair is visible on the byte outputs one cycle after the done strobe.
- R10: If low and high read strobes arrive in the same cycle, the release wins and the pair ends up unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_i | input | 10 | Result word from the conversion engine |
| done_i | input | 1 | One-cycle strobe: conversion finished |
| align_left_i | input | 1 | 1 = left alignment, 0 = right alignment |
| rd_lo_i | input | 1 | Bus read strobe for the low byte |
| rd_hi_i | input | 1 | Bus read strobe for the high byte |
| flag_clr_i | input | 1 | Clears the completion flag |
| data_lo_o | output | 8 | Low data byte |
| data_hi_o | output | 8 | High data byte |
| done_flag_o | output | 1 | Completion flag |

## Verification
The hardest case to reach is a completion that lands inside a low-then-high read window. The outputs must stay frozen while the flag still rises. The bench first stores a known sample. It then issues a low-byte strobe alone and pulses done with a very different word. It checks both bytes and the flag before it issues the high-byte strobe. A further completion confirms that the release took effect. The bench also drives both read strobes in the same cycle, and a done strobe together with a flag clear, to check the tie rules.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;
    localparam int ADC_RES_W  = 10;
    localparam int ADC_BYTE_W = 8;

    typedef struct packed {
        logic [ADC_RES_W-1:0] held;
        logic                 locked;
    } hold_state_t;
endpackage

// File: rtl/adc_res_hold.sv
module adc_res_hold
    import adc_res_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADC_RES_W-1:0] res_i,
    input  logic                 done_i,
    input  logic                 rd_lo_i,
    input  logic                 rd_hi_i,
    output logic [ADC_RES_W-1:0] held_o
);
    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (done_i && !st_q.locked) st_d.held = res_i;
        if (rd_hi_i)      st_d.locked = 1'b0;
        else if (rd_lo_i) st_d.locked = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;

    // R6
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> $stable(held_o));
    // R6
    lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_i && !rd_hi_i) |=> st_q.locked);
    // R7
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> !st_q.locked);
    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !st_q.locked) |=> (held_o == $past(res_i)));
endmodule

// File: rtl/adc_res_align.sv
module adc_res_align
    import adc_res_pkg::*;
#(
    parameter int RES_W  = ADC_RES_W,
    parameter int BYTE_W = ADC_BYTE_W
) (
    input  logic [RES_W-1:0]  held_i,
    input  logic              left_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o
);
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] pair_right, pair_left, pair_sel;

    always_comb begin
        pair_right = {{PAD_W{1'b0}}, held_i};
        pair_left  = {held_i, {PAD_W{1'b0}}};
        pair_sel   = left_i ? pair_left : pair_right;
        lo_o       = pair_sel[BYTE_W-1:0];
        hi_o       = pair_sel[PAIR_W-1:BYTE_W];
    end
endmodule

// File: rtl/adc_res_flag.sv
module adc_res_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R8
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_res_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADC_RES_W-1:0]  res_i,
    input  logic                  done_i,
    input  logic                  align_left_i,
    input  logic                  rd_lo_i,
    input  logic                  rd_hi_i,
    input  logic                  flag_clr_i,
    output logic [ADC_BYTE_W-1:0] data_lo_o,
    output logic [ADC_BYTE_W-1:0] data_hi_o,
    output logic                  done_flag_o
);
    localparam int PAD_W = 2 * ADC_BYTE_W - ADC_RES_W;

    logic [ADC_RES_W-1:0] held;

    adc_res_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .res_i   (res_i),
        .done_i  (done_i),
        .rd_lo_i (rd_lo_i),
        .rd_hi_i (rd_hi_i),
        .held_o  (held)
    );

    adc_res_align #(.RES_W(ADC_RES_W), .BYTE_W(ADC_BYTE_W)) u_align (
        .held_i (held),
        .left_i (align_left_i),
        .lo_o   (data_lo_o),
        .hi_o   (data_hi_o)
    );

    adc_res_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (done_i),
        .clr_i  (flag_clr_i),
        .flag_o (done_flag_o)
    );

    // R2
    right_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !align_left_i |-> (data_hi_o[ADC_BYTE_W-1:ADC_BYTE_W-PAD_W] == '0));
    // R3
    left_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_left_i |-> (data_lo_o[PAD_W-1:0] == '0));
endmodule

// File: tb/adc_result_regs_test.sv
module adc_result_regs_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] res_i = '0;
    logic       done_i = 1'b0, align_left_i = 1'b0;
    logic       rd_lo_i = 1'b0, rd_hi_i = 1'b0, flag_clr_i = 1'b0;
    logic [7:0] data_lo_o, data_hi_o;
    logic       done_flag_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_result_regs uut (.*);

    // entry: {result[9:0], left, expected low[7:0], expected high[7:0]}
    localparam logic [26:0] VEC [8] = '{
        {10'h3FF, 1'b0, 8'hFF, 8'h03},
        {10'h3FF, 1'b1, 8'hC0, 8'hFF},
        {10'h000, 1'b0, 8'h00, 8'h00},
        {10'h155, 1'b0, 8'h55, 8'h01},
        {10'h155, 1'b1, 8'h40, 8'h55},
        {10'h2AA, 1'b0, 8'hAA, 8'h02},
        {10'h2AA, 1'b1, 8'h80, 8'hAA},
        {10'h201, 1'b1, 8'h40, 8'h80}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic complete(input logic [9:0] v);
        @(negedge clk); res_i = v; done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
        #1;
    endtask

    task automatic strobe(input logic lo, input logic hi);
        @(negedge clk); rd_lo_i = lo; rd_hi_i = hi;
        @(negedge clk); rd_lo_i = 1'b0; rd_hi_i = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0; #1;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1 lo", data_lo_o, 8'h00);
        check("R1 hi", data_hi_o, 8'h00);
        check("R1 flag", {7'b0, done_flag_o}, 8'h00);
        rst_n = 1'b1;

        // R1 first entry is the first completion after reset; R2, R3, R9 layouts
        for (int i = 0; i < 8; i++) begin
            align_left_i = VEC[i][16];
            complete(VEC[i][26:17]);
            check(VEC[i][16] ? "R3/R9 lo" : "R2/R9 lo", data_lo_o, VEC[i][15:8]);
            check(VEC[i][16] ? "R3/R9 hi" : "R2/R9 hi", data_hi_o, VEC[i][7:0]);
        end

        // R5 re-format without a new conversion
        align_left_i = 1'b0;
        complete(10'h155);
        @(negedge clk); align_left_i = 1'b1; #1;
        check("R5 lo", data_lo_o, 8'h40);
        check("R5 hi", data_hi_o, 8'h55);
        @(negedge clk); align_left_i = 1'b0; #1;
        check("R5 back hi", data_hi_o, 8'h01);

        // R6 lock, dropped completion; R8 flag still set
        complete(10'h0F0);
        clear_flag();
        check("R8 cleared", {7'b0, done_flag_o}, 8'h00);
        strobe(1'b1, 1'b0);
        complete(10'h3FF);
        check("R6 lo frozen", data_lo_o, 8'hF0);
        check("R6 hi frozen", data_hi_o, 8'h00);
        check("R8 dropped sets flag", {7'b0, done_flag_o}, 8'h01);

        // R7 release then capture
        strobe(1'b0, 1'b1);
        check("R7 hi after release", data_hi_o, 8'h00);
        complete(10'h123);
        check("R7 lo", data_lo_o, 8'h23);
        check("R7 hi", data_hi_o, 8'h01);

        // R8 done and clear together: set wins
        @(negedge clk); res_i = 10'h0AA; done_i = 1'b1; flag_clr_i = 1'b1;
        @(negedge clk); done_i = 1'b0; flag_clr_i = 1'b0; #1;
        check("R8 set wins", {7'b0, done_flag_o}, 8'h01);

        // R10 simultaneous strobes leave the pair unlocked
        strobe(1'b1, 1'b1);
        complete(10'h2C3);
        check("R10 lo", data_lo_o, 8'hC3);
        check("R10 hi", data_hi_o, 8'h02);

        // R4 high-only reads in left alignment
        align_left_i = 1'b1;
        complete(10'h3F0);
        strobe(1'b0, 1'b1);
        #1;
        check("R4 hi", data_hi_o, 8'hFC);
        complete(10'h10C);
        check("R4 next capture", data_hi_o, 8'h43);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule